// File: doc/BRIEF.md
# Two-Phase Receive Character Presenter

This block takes the aligned 10-bit characters of a receive datapath and places them on a parallel output register. The register is qualified by two half-rate phase signals that are always complementary: every accepted character toggles them, so consecutive characters alternate between a rising edge of `ph0` and a rising edge of `ph1`. A downstream consumer captures the register on the rising edge of either phase. Each new character is loaded one clock cycle before the phase edge that announces it. It then stays unchanged for at least one character time after that edge.

The block runs on a core clock whose cycle is a fixed fraction of a character time (`CHR_CYC` cycles per character). When the aligner signals a one-character slip, the block makes sure the character that follows lands in the `ph1` slot. If `ph1` is already high, it inserts a single fill slot on `ph0` to achieve this. Otherwise it simply lets the current phase stretch. When the signal-valid flag is low, the phases free-run at half the locked rate and ignore the data strobe. No phase level is ever held for less than one character time. This holds across slips and across switches between the locked and free-running cadences. A character that arrives too early is held and launched later, never dropped.

Top module: `rxph_dual_out`

## Requirements
- R1: While reset is asserted, `ph0` is 0, `ph1` is 1 and `rx_data` is 0.
- R2: `ph0` is the complement of `ph1` in every cycle.
- R3: Every strobed character appears on `rx_data` exactly once and in arrival order. Each one is announced by the rising edge of the phase opposite to the one that rose last, so the first character after reset lands on `ph0`.
- R4: `rx_data` takes a new value exactly one clock cycle before the phase edge that announces it, and is unchanged across that edge.
- R5: Every high and low interval of the phase signals lasts at least `CHR_CYC` clock cycles.
- R6: A slip pulse while `ph1` is high produces one extra slot on `ph0` carrying `FILL` (default all zeros), so the next character lands on `ph1`.
- R7: A slip pulse while `ph0` is high adds no slot; `ph0` stays high until the next character, which lands on `ph1`.
- R8: While `sig_ok` is low, the phases toggle every `2*CHR_CYC` clock cycles, `chr_stb` is ignored and `rx_data` holds its value.
- R9: A character strobed fewer than `CHR_CYC` cycles after the last phase toggle is held and launched when that minimum interval has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, `CHR_CYC` cycles per character |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chr_stb | input | 1 | One-cycle strobe marking a valid aligned character |
| chr_data | input | DW | Character accompanying `chr_stb` |
| slip | input | 1 | One-cycle pulse in a character slot where the aligner slipped; never together with `chr_stb` |
| sig_ok | input | 1 | High while the receive signal is valid |
| ph0 | output | 1 | Phase for odd characters of a word |
| ph1 | output | 1 | Phase for even characters, comma slot |
| rx_data | output | DW | Registered output character |

## Verification
If the pending or fill state is wrong, it shows at the very next phase edge. The consumer then sees a repeated, missing or misplaced character, or a fill slot on the wrong phase. If the age counter is wrong, some high or low time becomes shorter than a character, or the free-running period departs from twice the character time. Either fault is visible within one or two phase periods of the event that caused it. If the data and phase registers are skewed, the register changes at the same edge as the phase instead of one cycle ahead, and this shows on the first character after the fault.

// File: rtl/rxph_pkg.sv
package rxph_pkg;
  // Action chosen for the current cycle by the slot controller
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_CHAR = 2'd1,
    SLOT_FILL = 2'd2,
    SLOT_REF  = 2'd3
  } slot_act_e;
endpackage

// File: rtl/rxph_age_ctr.sv
module rxph_age_ctr #(
  parameter int CHR_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic age_ok,
  output logic ref_due
);
  localparam int REF_HALF = 2 * CHR_CYC;
  localparam int AW       = $clog2(REF_HALF + 1);

  logic [AW-1:0] age_q, age_n;

  always_comb begin
    if (restart)
      age_n = '0;
    else if (age_q == AW'(REF_HALF - 1))
      age_n = age_q;
    else
      age_n = age_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_n;
  end

  assign age_ok  = (age_q >= AW'(CHR_CYC - 1));
  assign ref_due = (age_q == AW'(REF_HALF - 1));
endmodule

// File: rtl/rxph_slot_ctl.sv
module rxph_slot_ctl
  import rxph_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_stb,
  input  logic [DW-1:0] chr_data,
  input  logic          slip,
  input  logic          sig_ok,
  input  logic          age_ok,
  input  logic          ref_due,
  input  logic          ph1_cmd,
  output slot_act_e     act,
  output logic [DW-1:0] act_data
);
  logic          pend_q, pend_n;
  logic [DW-1:0] pdat_q, pdat_n;
  logic          fix_q, fix_n;
  logic          want_fix;

  assign want_fix = (slip | fix_q) & ph1_cmd;

  always_comb begin
    act      = SLOT_IDLE;
    act_data = chr_data;
    pend_n   = pend_q;
    pdat_n   = pdat_q;
    fix_n    = fix_q;
    if (!sig_ok) begin
      pend_n = 1'b0;
      fix_n  = 1'b0;
      if (ref_due) act = SLOT_REF;
    end else if (age_ok && pend_q) begin
      act      = SLOT_CHAR;
      act_data = pdat_q;
      pend_n   = chr_stb;
      pdat_n   = chr_data;
      fix_n    = fix_q | slip;
    end else if (age_ok && want_fix) begin
      act    = SLOT_FILL;
      fix_n  = 1'b0;
      pend_n = chr_stb;
      pdat_n = chr_data;
    end else if (age_ok && chr_stb) begin
      act   = SLOT_CHAR;
      fix_n = 1'b0;
    end else begin
      if (chr_stb) begin
        pend_n = 1'b1;
        pdat_n = chr_data;
      end
      fix_n = want_fix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pdat_q <= '0;
      fix_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      pdat_q <= pdat_n;
      fix_q  <= fix_n;
    end
  end
endmodule

// File: rtl/rxph_out_stage.sv
module rxph_out_stage
  import rxph_pkg::*;
#(
  parameter int            DW   = 10,
  parameter logic [DW-1:0] FILL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_act_e     act,
  input  logic [DW-1:0] act_data,
  output logic          ph1_cmd,
  output logic          ph0_o,
  output logic          ph1_o,
  output logic [DW-1:0] data_o
);
  logic          cmd_q, cmd_n;
  logic          out_q;
  logic [DW-1:0] data_q, data_n;

  always_comb begin
    cmd_n = cmd_q ^ (act != SLOT_IDLE);
    unique case (act)
      SLOT_CHAR: data_n = act_data;
      SLOT_FILL: data_n = FILL;
      default:   data_n = data_q;
    endcase
  end

  // Phase output trails the command by one cycle so data leads its edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b1;
      out_q  <= 1'b1;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      out_q  <= cmd_q;
      data_q <= data_n;
    end
  end

  assign ph1_cmd = cmd_q;
  assign ph1_o   = out_q;
  assign ph0_o   = ~out_q;
  assign data_o  = data_q;
endmodule

// File: rtl/rxph_dual_out.sv
module rxph_dual_out
  import rxph_pkg::*;
#(
  parameter int            DW      = 10,
  parameter int            CHR_CYC = 4,
  parameter logic [DW-1:0] FILL    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_stb,
  input  logic [DW-1:0] chr_data,
  input  logic          slip,
  input  logic          sig_ok,
  output logic          ph0,
  output logic          ph1,
  output logic [DW-1:0] rx_data
);
  slot_act_e     act;
  logic [DW-1:0] act_data;
  logic          age_ok, ref_due, ph1_cmd;

  rxph_age_ctr #(.CHR_CYC(CHR_CYC)) age_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (act != SLOT_IDLE),
    .age_ok  (age_ok),
    .ref_due (ref_due)
  );

  rxph_slot_ctl #(.DW(DW)) ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chr_stb  (chr_stb),
    .chr_data (chr_data),
    .slip     (slip),
    .sig_ok   (sig_ok),
    .age_ok   (age_ok),
    .ref_due  (ref_due),
    .ph1_cmd  (ph1_cmd),
    .act      (act),
    .act_data (act_data)
  );

  rxph_out_stage #(.DW(DW), .FILL(FILL)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .act_data (act_data),
    .ph1_cmd  (ph1_cmd),
    .ph0_o    (ph0),
    .ph1_o    (ph1),
    .data_o   (rx_data)
  );
endmodule

// File: rtl/rxph_dual_out_chk.sv
module rxph_dual_out_chk #(
  parameter int DW      = 10,
  parameter int CHR_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sig_ok,
  input logic          ph0,
  input logic          ph1,
  input logic [DW-1:0] rx_data
);
  localparam int RW = $clog2(CHR_CYC + 1);

  logic          last_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else begin
      last_q <= ph1;
      if (ph1 != last_q)               run_q <= RW'(1);
      else if (run_q != RW'(CHR_CYC))  run_q <= run_q + RW'(1);
    end
  end

  assert_antiphase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph0 != ph1);

  assert_data_leads_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data != $past(rx_data)) |=> (ph1 != $past(ph1)));

  assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph1 != last_q) |-> (run_q >= RW'(CHR_CYC)));

  assert_hold_when_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_ok && $past(!sig_ok)) |-> $stable(rx_data));
endmodule

bind rxph_dual_out rxph_dual_out_chk #(.DW(DW), .CHR_CYC(CHR_CYC)) chk_i (.*);

// File: tb/rxph_dual_out_tb_top.sv
module rxph_dual_out_tb_top;
  localparam int DW = 10;
  localparam int CC = 4;
  localparam logic [DW-1:0] FILLV = '0;

  logic clk = 1'b0;
  logic rst_n, chr_stb, slip, sig_ok;
  logic [DW-1:0] chr_data;
  logic ph0, ph1;
  logic [DW-1:0] rx_data;

  always #5 clk = ~clk;

  rxph_dual_out #(.DW(DW), .CHR_CYC(CC), .FILL(FILLV)) dut_i (
    .clk(clk), .rst_n(rst_n), .chr_stb(chr_stb), .chr_data(chr_data),
    .slip(slip), .sig_ok(sig_ok), .ph0(ph0), .ph1(ph1), .rx_data(rx_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_d [0:63];
  bit exp_p [0:63];
  int wr = 0, rd = 0;
  bit last_rise = 1'b1;
  bit watch = 1'b0;
  int cyc = 0, chg_cnt = 0, chg_cyc = 0;
  int run = 0, short_cnt = 0, anti_bad = 0;
  logic prev_ph1 = 1'b1;
  logic [DW-1:0] prev_data = '0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // Port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      cyc++;
      if (ph0 == ph1) anti_bad++;
      if (ph1 != prev_ph1) begin
        if (run < CC) short_cnt++;
        run = 1;
        chg_cnt++;
        chg_cyc = cyc;
        if (watch) begin
          // R3: next expected character on the expected phase
          if (rd < wr) begin
            check(exp_d[rd] == rx_data && exp_p[rd] == ph1, "R3 order/phase",
                  {ph1, rx_data}, {exp_p[rd], exp_d[rd]});
            rd++;
          end else begin
            check(1'b0, "R3 unexpected character", rx_data, 0);
          end
          // R4: data unchanged across the announcing edge
          check(rx_data == prev_data, "R4 data stable across edge", rx_data, prev_data);
        end
      end else begin
        run++;
      end
      prev_ph1  = ph1;
      prev_data = rx_data;
    end
  end

  task automatic slot(bit s, bit sl, logic [DW-1:0] d, int len);
    chr_stb = s; slip = sl; chr_data = d;
    @(negedge clk);
    chr_stb = 1'b0; slip = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic push(logic [DW-1:0] d, bit p);
    exp_d[wr] = d; exp_p[wr] = p; wr++;
    last_rise = p;
  endtask

  task automatic send_char(logic [DW-1:0] d, int len);
    push(d, ~last_rise);
    slot(1'b1, 1'b0, d, len);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    int c0, t1, t2;
    logic [DW-1:0] hold_v;
    rst_n = 1'b0; chr_stb = 1'b0; slip = 1'b0; sig_ok = 1'b1; chr_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ph0 == 1'b0, "R1 ph0 in reset", ph0, 0);
    check(ph1 == 1'b1, "R1 ph1 in reset", ph1, 1);
    check(rx_data == '0, "R1 data in reset", rx_data, 0);
    rst_n = 1'b1;
    watch = 1'b1;
    repeat (5) @(negedge clk);

    // R3: back-to-back characters, then a slower cadence
    for (int i = 0; i < 8; i++) send_char(DW'(10'h101 + i), CC);
    for (int i = 0; i < 6; i++) send_char(DW'(10'h210 + 3 * i), CC + 2);

    // R6: slip while ph1 high -> fill slot on ph0, comma on ph1
    push(FILLV, 1'b0);
    slot(1'b0, 1'b1, '0, CC);
    send_char(10'h17c, CC);
    check(last_rise == 1'b1, "R6 comma expected on ph1", last_rise, 1);
    send_char(10'h055, CC);

    // R7: slip while ph0 high -> stretch only, next char on ph1
    slot(1'b0, 1'b1, '0, CC);
    send_char(10'h17c, CC);
    send_char(10'h066, CC);
    repeat (10) @(negedge clk);
    check(rd == wr, "R3 R6 R7 all slots delivered", rd, wr);

    // R8: invalid signal -> free-running half-rate cadence, data held
    watch = 1'b0;
    hold_v = rx_data;
    sig_ok = 1'b0;
    chr_stb = 1'b1; chr_data = 10'h3ff;
    c0 = chg_cnt;
    while (chg_cnt < c0 + 1) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      t1 = chg_cyc;
      c0 = chg_cnt;
      while (chg_cnt < c0 + 1) @(negedge clk);
      t2 = chg_cyc;
      check(t2 - t1 == 2 * CC, "R8 reference half period", t2 - t1, 2 * CC);
    end
    check(rx_data == hold_v, "R8 data held, strobe ignored", rx_data, hold_v);
    chr_stb = 1'b0;

    // R9: valid again right after a toggle -> early char deferred
    c0 = chg_cnt;
    while (chg_cnt < c0 + 1) @(negedge clk);
    last_rise = ph1;
    watch = 1'b1;
    sig_ok = 1'b1;
    send_char(10'h2a5, CC);
    send_char(10'h15a, CC);
    repeat (12) @(negedge clk);
    check(rd == wr, "R9 deferred characters delivered", rd, wr);

    check(anti_bad == 0, "R2 phases complementary", anti_bad, 0);
    check(short_cnt == 0, "R5 no short phase interval", short_cnt, 0);
    finish_up();
  end
endmodule